// File: doc/BRIEF.md
# Auto-Reload Down-Counter Timer

This block is a 13-bit timer that counts down and raises an interrupt request each time its countdown ends. It then reloads itself from a programmed start value, so a steady stream of ticks produces a steady stream of interrupts. One 16-bit control word sets it up. The word holds the start value, a choice of tick source, a run bit and an enable bit. Ticks come either from the system clock divided by two or from a terminal-count strobe that another counter supplies on `ext_tick`. The second source lets two timers chain into one wider timer.

The control word is written through a plain single-cycle write strobe. There is no handshake, and every strobed write is accepted at once. The only output is a one-clock interrupt strobe. Clearing the enable bit is one-way: only reset turns the enable back on. A start value of zero never produces an interrupt. If zero is written while a countdown is in progress, that countdown finishes with one last interrupt and the timer then stays idle, which gives a single-pass mode.

Control word layout: bit 15 is enable, bit 14 is run, bit 13 is tick source (0 = clock divided by two, 1 = `ext_tick`), and bits 12:0 are the start value.

Top module: `autoreload_timer`

## Requirements
- R1: After reset the control word is enabled, stopped, source clock/2, start value 0. `irq` stays low until a running configuration is written, whatever `ext_tick` does.
- R2: A write with a nonzero start value N loads the counter at once. Any countdown in progress is discarded. The write cycle itself never counts as a tick.
- R3: With source clock/2, ticks fall on every second clock edge after a write. The first `irq` is high in the cycle after edge 2N, counting the write edge as edge 0.
- R4: With source `ext_tick` (bit 13 = 1), each clock edge that samples `ext_tick` high is one tick. `irq` is high after the N-th such tick.
- R5: `irq` is a one-clock strobe on the tick that ends a countdown. The counter reloads N on that same tick, so the strobes repeat every N ticks. With N = 1 and a tick on every edge, `irq` stays high.
- R6: With run (bit 14) at 0, no ticks are taken and `irq` stays low.
- R7: Once a write clears enable (bit 15), `irq` stays low even after later writes set bit 15 again, until reset.
- R8: A write with start value 0 does not load the counter. A countdown already in progress ends with one final `irq` and then the timer stays idle. When the counter is already idle, no `irq` ever follows.
- R9: The control word 0xC008 gives one `irq` every 16 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe, one clock per write |
| wr_data | input | 16 | Control word (enable, run, source, start value) |
| ext_tick | input | 1 | Terminal-count strobe from another counter, one tick per high clock |
| irq | output | 1 | Interrupt request strobe |

## Verification
The assertions assume the following about the inputs:
- `wr_en` is a clean, synchronous strobe.
- `ext_tick` is already synchronous to `clk`, so each sampled high level is one tick.
- The checks on counter hold and reload rest on the rule that a write cycle never also carries a tick.

The stimulus drives all inputs on the falling edge and raises `wr_en` for exactly one clock per write. It places external tick pulses at fixed spacings, from every edge to every third edge. All interrupt timing is then computed from the tick count and that spacing.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W = 13;
  localparam int REG_W = CNT_W + 3;

  // Field order is the control word bit order: enable at the top.
  typedef struct packed {
    logic             enable;
    logic             run;
    logic             sel_ext;
    logic [CNT_W-1:0] count;
  } tmr_ctrl_t;

  localparam tmr_ctrl_t CTRL_RST = '{enable: 1'b1, run: 1'b0, sel_ext: 1'b0, count: '0};
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  tmr_ctrl_t wr_ctrl,
  output tmr_ctrl_t ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_en) begin
      ctrl_q.count   <= wr_ctrl.count;
      ctrl_q.sel_ext <= wr_ctrl.sel_ext;
      ctrl_q.run     <= wr_ctrl.run;
      // enable can only be cleared by software
      ctrl_q.enable  <= ctrl_q.enable & wr_ctrl.enable;
    end
  end

  a_r7_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.enable |=> !ctrl_q.enable);
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PRE_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic active,
  input  logic sel_ext,
  input  logic ext_tick,
  output logic tick
);
  logic div_tick;

  generate
    if (PRE_DIV > 1) begin : g_pre
      localparam int PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pre_q <= '0;
        else if (clr || !active)    pre_q <= '0;
        else if (pre_q == LAST)     pre_q <= '0;
        else                        pre_q <= pre_q + 1'b1;
      end

      assign div_tick = active && !clr && (pre_q == LAST);

      a_r3_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sel_ext) |=> !tick);
    end else begin : g_nopre
      assign div_tick = active && !clr;
    end
  endgenerate

  assign tick = sel_ext ? (active && !clr && ext_tick) : div_tick;
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload_val,
  input  logic          tick,
  output logic [CW-1:0] count_q,
  output logic          irq
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (load) begin
        count_q <= load_val;
      end else if (tick && count_q != '0) begin
        if (count_q == ONE) begin
          count_q <= reload_val;
          irq     <= 1'b1;
        end else begin
          count_q <= count_q - ONE;
        end
      end
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_q == $past(load_val));
  a_r5_irq_reload: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> count_q == reload_val);
  a_r5_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !irq);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count_q));
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !load) |=> (count_q == '0 && !irq));
endmodule

// File: rtl/autoreload_timer.sv
module autoreload_timer
  import timer_pkg::*;
#(
  parameter int PRE_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ext_tick,
  output logic             irq
);
  tmr_ctrl_t        wr_ctrl;
  tmr_ctrl_t        ctrl_q;
  logic             active;
  logic             tick;
  logic             load;
  logic [CNT_W-1:0] cnt_q;

  assign wr_ctrl = tmr_ctrl_t'(wr_data);
  assign active  = ctrl_q.enable && ctrl_q.run;
  assign load    = wr_en && (wr_ctrl.count != '0);

  tmr_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ctrl (wr_ctrl),
    .ctrl_q  (ctrl_q)
  );

  tmr_tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (wr_en),
    .active   (active),
    .sel_ext  (ctrl_q.sel_ext),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  tmr_down_cnt #(.CW(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_val   (wr_ctrl.count),
    .reload_val (ctrl_q.count),
    .tick       (tick),
    .count_q    (cnt_q),
    .irq        (irq)
  );

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.enable && $past(!ctrl_q.enable)) |-> !irq);
  a_r5_irq_from_one: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cnt_q) == CNT_W'(1)));
endmodule

// File: tb/autoreload_timer_tb.sv
module autoreload_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ext_tick = 1'b0;
  logic        irq;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  autoreload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ext_tick(ext_tick), .irq(irq)
  );

  function automatic logic [15:0] mk(bit en, bit run, bit sel, int n);
    return {en, run, sel, 13'(n)};
  endfunction

  task automatic check(logic got, logic exp, string req, int k);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s edge %0d: irq=%0b expected %0b", req, k, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; ext_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // ends at the falling edge after the capturing edge (edge 0)
  task automatic do_write(logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // period 0: irq never; once: only at edge == period
  task automatic watch(int n, int period, int p_ext, bit once, string req);
    for (int k = 1; k <= n; k++) begin
      ext_tick = (p_ext > 0) && (k % p_ext == 0);
      @(posedge clk);
      @(negedge clk);
      if (period == 0)  check(irq, 1'b0, req, k);
      else if (once)    check(irq, k == period, req, k);
      else              check(irq, (k % period) == 0, req, k);
    end
    ext_tick = 1'b0;
  endtask

  initial begin
    #800us;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state quiet even with ext ticks present
    watch(20, 0, 1, 0, "R1");
    // R9: 0xC008 gives irq every 16 clocks (also R1 default enable)
    do_write(16'hC008);
    watch(48, 16, 0, 0, "R9");
    // R3/R5: clock/2 sweep
    for (int n = 1; n <= 20; n++) begin
      do_write(mk(1, 1, 0, n));
      watch(6 * n, 2 * n, 0, 0, "R3");
    end
    // R4/R5: external tick sweep
    for (int n = 1; n <= 6; n++)
      for (int p = 1; p <= 3; p++) begin
        do_write(mk(1, 1, 1, n));
        watch(3 * n * p, n * p, p, 0, "R4");
      end
    // R5: N=1 with tick every edge keeps irq high
    do_write(mk(1, 1, 1, 1));
    watch(10, 1, 1, 0, "R5");
    // R2: rewrite mid-countdown discards old count
    do_write(mk(1, 1, 0, 10));
    repeat (5) @(posedge clk);
    do_write(mk(1, 1, 0, 3));
    watch(18, 6, 0, 0, "R2");
    // R2/R3: largest start value
    do_write(mk(1, 1, 0, 8191));
    watch(16384, 16382, 0, 1, "R2");
    do_write(mk(1, 1, 1, 8191));
    watch(8193, 8191, 1, 1, "R4");
    // R6: stopped timer is quiet, then runs
    do_write(mk(1, 0, 0, 3));
    watch(40, 0, 1, 0, "R6");
    do_write(mk(1, 1, 0, 3));
    watch(18, 6, 0, 0, "R6");
    // R8: zero while counting -> one final irq
    do_write(mk(1, 1, 0, 5));
    repeat (2) @(posedge clk);
    do_write(mk(1, 1, 0, 0));
    watch(40, 8, 0, 1, "R8");
    // R8: zero from idle -> never
    do_reset();
    do_write(mk(1, 1, 0, 0));
    watch(30, 0, 1, 0, "R8");
    do_write(mk(1, 1, 1, 0));
    watch(30, 0, 1, 0, "R8");
    // R7: disable is sticky until reset
    do_write(mk(0, 1, 0, 3));
    watch(40, 0, 0, 0, "R7");
    do_write(mk(1, 1, 0, 3));
    watch(40, 0, 0, 0, "R7");
    do_write(mk(1, 1, 1, 2));
    watch(20, 0, 1, 0, "R7");
    do_reset();
    do_write(mk(1, 1, 0, 3));
    watch(18, 6, 0, 0, "R7");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule